// File: doc/BRIEF.md
# Flat Page Table Walker

This block converts 32-bit virtual addresses into physical addresses by reading one descriptor from a single-level table held in memory. The virtual space is 4 GB and only 4 KB pages exist, so the table holds one 4-byte descriptor per virtual page: 2^20 entries, exactly 4 MB. Software programs the table base through a write port. It may write the base again at any time, for example to restore it after a power-down.

A client raises a lookup with a virtual address. The block computes the descriptor address, issues one read on a simple request/response memory port and waits for the data. It then decodes the descriptor and presents either a physical address or a translation fault that carries the faulting virtual address. Only one lookup is in flight at a time. A busy output tells the client when a new request will be taken. Results are not cached.

Top module: `pgw_top`

## Requirements
- R1: While reset is asserted and in the cycle after it, `busy`, `rsp_valid` and `mem_req_valid` are low.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the cycle in which `rsp_valid` is high. Requests presented while `busy` is high are ignored and issue no memory read.
- R3: Exactly one memory read is issued per accepted lookup, as a one-cycle `mem_req_valid` pulse in the cycle after acceptance. Its address is the base plus (VA >> 12) * 4, computed modulo 2^32.
- R4: If descriptor bit 1 (valid) is set, `rsp_fault` is 0 and `rsp_pa` equals descriptor bits 31:12 followed by VA bits 11:0.
- R5: On a successful translation, `rsp_nonsec` reports descriptor bit 3.
- R6: If descriptor bit 1 is clear, the lookup faults. This includes the all-zero descriptor of an unmapped page and a descriptor with only bit 3 set. A fault drives `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_nonsec` = 0.
- R7: `rsp_valid` is a one-cycle pulse in the cycle after the edge that samples `mem_rsp_valid` while the block waits for data. `busy` is low in the cycle after that pulse.
- R8: A base write takes effect for lookups accepted after the write edge. A lookup already in flight keeps the address it computed.
- R9: `mem_rsp_valid` while no read is outstanding is ignored: no response and no change of `busy`.
- R10: Descriptor bits other than 31:12, 1 and 3 have no effect on the result.
- R11: `rsp_fault_va` returns the virtual address of the lookup being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table base write strobe |
| cfg_base | input | 32 | Table base value to write |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | Lookup in progress; new requests ignored |
| mem_req_valid | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Lookup result valid (one-cycle pulse) |
| rsp_fault | output | 1 | Translation fault |
| rsp_nonsec | output | 1 | Non-secure flag of the translated page |
| rsp_pa | output | 32 | Physical address, zero on fault |
| rsp_fault_va | output | 32 | Virtual address of the answered lookup |

## Verification
The memory read is due exactly one cycle after the accepting edge. The result is due exactly one cycle after the edge that takes the memory data. A lookup answered with memory latency L therefore shows `rsp_valid` on the (3+L)-th falling edge after the request is raised. The bench's memory model counts that latency itself. Each check samples on falling edges at that computed count and compares the cycle count as well as the values. `busy` is checked on the first falling edge after acceptance and on the edge after the result. Stray memory data and held requests are each watched over several cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned PAGE_SHIFT  = 12;
  localparam int unsigned ENTRY_SHIFT = 2;
  localparam int unsigned VALID_POS   = 1;
  localparam int unsigned NS_POS      = 3;
  localparam int unsigned VPN_W       = ADDR_W - PAGE_SHIFT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic              fault;
    logic              nonsec;
    logic [ADDR_W-1:0] pa;
  } xlate_res_t;

  // Byte address of the descriptor for a virtual address (wraps modulo 2^ADDR_W).
  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [ADDR_W-1:0] va);
    logic [ADDR_W-1:0] off;
    off = (va >> PAGE_SHIFT) << ENTRY_SHIFT;
    return base + off;
  endfunction

  // Turn a descriptor plus the virtual address into a result.
  function automatic xlate_res_t decode_entry(input logic [ADDR_W-1:0] desc,
                                              input logic [ADDR_W-1:0] va);
    xlate_res_t        r;
    logic [ADDR_W-1:0] hi_mask;
    hi_mask  = {ADDR_W{1'b1}} << PAGE_SHIFT;
    r.fault  = !desc[VALID_POS];
    r.nonsec = desc[VALID_POS] & desc[NS_POS];
    r.pa     = desc[VALID_POS] ? ((desc & hi_mask) | (va & ~hi_mask)) : '0;
    return r;
  endfunction
endpackage

// File: rtl/pgw_base_reg.sv
module pgw_base_reg
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (cfg_we) base_q <= cfg_base;
  end

  assert_base_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> base_q == $past(cfg_base));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] base_q,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] va_q,
  output logic [ADDR_W-1:0] desc_q
);
  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] addr_q;

  // Named internal events
  logic accept;
  logic capture;
  assign accept  = req_valid && (st_q == ST_IDLE);
  assign capture = mem_rsp_valid && (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)  st_d = ST_ISSUE;
      ST_ISSUE:              st_d = ST_WAIT;
      ST_WAIT:  if (capture) st_d = ST_DONE;
      ST_DONE:               st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      va_q   <= '0;
      desc_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        va_q   <= req_va;
        addr_q <= entry_addr(base_q, req_va);
      end
      if (capture) desc_q <= mem_rsp_data;
    end
  end

  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign busy          = (st_q != ST_IDLE);
  assign rsp_valid     = (st_q == ST_DONE);

  assert_issue_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req_valid && mem_req_addr == entry_addr($past(base_q), $past(req_va)));
  assert_issue_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid && busy);
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rsp_valid && desc_q == $past(mem_rsp_data));
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);
  assert_stray_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !busy && !req_valid) |=> !busy && !rsp_valid);
  assert_addr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(mem_req_addr));
endmodule

// File: rtl/pgw_decode.sv
module pgw_decode
  import pgw_pkg::*;
(
  input  logic [ADDR_W-1:0] va_q,
  input  logic [ADDR_W-1:0] desc_q,
  output logic              fault,
  output logic              nonsec,
  output logic [ADDR_W-1:0] pa
);
  xlate_res_t res;
  assign res    = decode_entry(desc_q, va_q);
  assign fault  = res.fault;
  assign nonsec = res.nonsec;
  assign pa     = res.pa;
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_nonsec,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [ADDR_W-1:0] rsp_fault_va
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] desc_q;

  pgw_base_reg u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_base (cfg_base),
    .base_q   (base_q)
  );

  pgw_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .base_q        (base_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .va_q          (va_q),
    .desc_q        (desc_q)
  );

  pgw_decode u_dec (
    .va_q   (va_q),
    .desc_q (desc_q),
    .fault  (rsp_fault),
    .nonsec (rsp_nonsec),
    .pa     (rsp_pa)
  );

  assign rsp_fault_va = va_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !rsp_valid && !mem_req_valid);
  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0) && !rsp_nonsec);
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_pa[PAGE_SHIFT-1:0] == rsp_fault_va[PAGE_SHIFT-1:0]);
endmodule

// File: tb/sim_pgw_top.sv
module sim_pgw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        busy, mem_req_valid, rsp_valid, rsp_fault, rsp_nonsec;
  logic [31:0] mem_req_addr, rsp_pa, rsp_fault_va;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  pgw_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_va(req_va), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
    .rsp_pa(rsp_pa), .rsp_fault_va(rsp_fault_va)
  );

  int total = 0;
  int bad = 0;

  // Sparse table memory model
  logic [31:0] mem_m [logic [31:0]];
  int          cur_lat = 0;
  int          cnt = 0;
  bit          pend = 0;
  bit          inject = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] last_addr = '0;
  int          mem_reqs = 0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    if (rst_n) begin
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_m.exists(pend_addr) ? mem_m[pend_addr] : 32'h0;
          pend = 0;
        end else cnt--;
      end else if (inject) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFF_F00A;
        inject = 0;
      end
      if (mem_req_valid) begin
        pend = 1;
        cnt = cur_lat;
        pend_addr = mem_req_addr;
        last_addr = mem_req_addr;
        mem_reqs++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    cfg_we = 1'b1;
    cfg_base = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] base_exp, input logic [31:0] va, input logic [31:0] desc,
                      input int lat, input bit hold, input bit mid, input logic [31:0] nb);
    logic [31:0] ea;
    logic        e_fault, e_ns;
    logic [31:0] e_pa;
    int          n;
    int          reqs0;
    bit          seen;
    ea      = base_exp + ((va >> 12) << 2);
    e_fault = (desc[1] == 1'b0);
    e_pa    = e_fault ? 32'h0 : {desc[31:12], va[11:0]};
    e_ns    = !e_fault && desc[3];
    if (desc != 0) mem_m[ea] = desc;
    cur_lat = lat;
    reqs0 = mem_reqs;
    req_valid = 1'b1;
    req_va = va;
    n = 0;
    seen = 0;
    while (!seen && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        if (hold) req_va = va ^ 32'h5555_5000;
        else req_valid = 1'b0;
        if (mid) begin cfg_we = 1'b1; cfg_base = nb; end
      end
      if (n == 2 && mid) cfg_we = 1'b0;
      if (rsp_valid) seen = 1;
    end
    req_valid = 1'b0;
    chk(seen, "R7 response seen", 32'(seen), 32'd1);
    chk(n == 3 + lat, "R7 response cycle", 32'(n), 32'(3 + lat));
    chk(last_addr == ea, "R3 descriptor address", last_addr, ea);
    chk(mem_reqs - reqs0 == 1, "R3 single read", 32'(mem_reqs - reqs0), 32'd1);
    chk(rsp_fault == e_fault, "R6 fault flag", 32'(rsp_fault), 32'(e_fault));
    chk(rsp_pa == e_pa, "R4 physical address", rsp_pa, e_pa);
    chk(rsp_nonsec == e_ns, "R5 non-secure flag", 32'(rsp_nonsec), 32'(e_ns));
    chk(rsp_fault_va == va, "R11 lookup va", rsp_fault_va, va);
    @(negedge clk);
    chk(!busy && !rsp_valid, "R7 idle after result", {30'd0, busy, rsp_valid}, 32'd0);
    @(negedge clk);
    chk(mem_reqs - reqs0 == 1, "R2 no extra read", 32'(mem_reqs - reqs0), 32'd1);
    if (desc != 0) mem_m.delete(ea);
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] va;
    logic [31:0] desc;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{32'h8000_0000, 32'h0000_1234, 32'h1234_500A, 4'd0},  // R4 R5 mapped, non-secure
    '{32'h8000_0000, 32'hFFFF_FFFF, 32'hABCD_E002, 4'd2},  // R4 top table entry
    '{32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 4'd1},  // R6 unmapped (all zero)
    '{32'h4000_0000, 32'h1234_5678, 32'h0000_0008, 4'd3},  // R6 bit 3 only
    '{32'hFFFF_F000, 32'h0040_0ABC, 32'h7654_3FF7, 4'd0},  // R10 junk low bits, R3 wrap
    '{32'h1000_0000, 32'h8000_0FFF, 32'hFFFF_F00A, 4'd5},  // R4 R5 all-ones page
    '{32'h1000_0000, 32'h0001_0000, 32'h0000_1001, 4'd0},  // R6 bit 0 not valid
    '{32'h0000_0000, 32'h0000_3000, 32'h0000_000A, 4'd1}   // R4 physical page zero
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req_valid, "R1 during reset",
        {29'd0, busy, rsp_valid, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req_valid, "R1 after reset",
        {29'd0, busy, rsp_valid, mem_req_valid}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      set_base(VT[i].base);
      walk(VT[i].base, VT[i].va, VT[i].desc, int'(VT[i].lat), 1'b0, 1'b0, 32'h0);
    end

    // R9: stray memory data while idle
    inject = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!rsp_valid && !busy, "R9 stray data ignored", {30'd0, busy, rsp_valid}, 32'd0);
    end

    // R2: request held high with a changing va while busy
    set_base(32'h2000_0000);
    walk(32'h2000_0000, 32'h0ABC_D123, 32'h5555_6002, 2, 1'b1, 1'b0, 32'h0);

    // R8: base rewritten while a lookup is in flight
    walk(32'h2000_0000, 32'h0000_5010, 32'h0001_100A, 3, 1'b0, 1'b1, 32'h3000_0000);
    walk(32'h3000_0000, 32'h0000_5010, 32'h0002_2002, 1, 1'b0, 1'b0, 32'h0);

    // R8: rewrite of the base (restore) applies immediately to the next lookup
    set_base(32'h2000_0000);
    walk(32'h2000_0000, 32'h0000_6FFF, 32'h0009_9002, 0, 1'b0, 1'b0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule